// File: doc/BRIEF.md
# Split-Bus DMA Byte Port

This block is an 8-bit data port that moves bytes between an external DMA controller and an endpoint FIFO held inside the block. It has its own data path, separate from any CPU bus. The port raises a request level whenever the FIFO can take a byte (IN direction) or holds a byte (OUT direction). An external controller answers with an acknowledge and then pulses an active-low data strobe once per byte. Each completed strobe, one with acknowledge held the whole time, moves exactly one byte. The on-chip core works the other end of the FIFO: it drains it in IN direction and fills it in OUT direction.

A static configuration input chooses the pipe direction and the active level of request, acknowledge and end-of-transfer. The end-of-transfer signal turns around with the direction. In OUT direction the port drives it while the byte on the bus is the last one the FIFO holds. In IN direction it is an input, and it sets a sticky completion flag that the core clears.

Each byte is sequenced by a three-state machine. S_IDLE waits for an active acknowledge and moves to S_ARMED when it arrives. S_ARMED waits for the strobe to fall and moves to S_LOW; it falls back to S_IDLE if acknowledge drops. S_LOW waits for the strobe to rise. On that rising edge it moves the byte and returns to S_ARMED, or returns to S_IDLE with no transfer if acknowledge dropped first.

Top module: `dma_split_port`

## Requirements
- R1: After reset the FIFO is empty (`core_rd_valid` low), the completion flag is clear and `sd_oe` is low.
- R2: In IN direction (`cfg_dir_in`=1), each completed strobe writes `sd_i` into the FIFO, and the core reads the bytes back in arrival order on `core_rd_data`, popping with `core_rd_en`.
- R3: In IN direction the request is active while the FIFO has a free entry and inactive while it is full.
- R4: In OUT direction (`cfg_dir_in`=0) the request is active while the FIFO holds at least one byte and inactive while it is empty.
- R5: In OUT direction, while acknowledge is active, `sd_oe` is high and `sd_o` shows the oldest stored byte; each completed strobe removes that byte.
- R6: A strobe pulse given while acknowledge is inactive moves no data.
- R7: With `cfg_ack_pol`=1 acknowledge is active when `dack` is high; with `cfg_ack_pol`=0 it is active when `dack` is low.
- R8: `dreq` equals `cfg_req_pol` when the request is active and its inverse when it is inactive.
- R9: In OUT direction `dend_oe` is high, and `dend_o` sits at the level `cfg_end_pol` exactly while acknowledge is active and the FIFO holds one byte; otherwise it sits at the inverse level.
- R10: In IN direction `dend_oe` is low, and a `dend_i` level equal to `cfg_end_pol` sets `done_flag`. The flag stays set until `core_done_clr`, and setting wins over clearing.
- R11: If acknowledge goes inactive between the strobe falling and rising, that byte is not transferred.
- R12: A completed strobe in IN direction while the FIFO is full does not write, and the stored bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir_in | input | 1 | 1 = IN (bus to FIFO), 0 = OUT (FIFO to bus) |
| cfg_req_pol | input | 1 | Active level of `dreq` |
| cfg_ack_pol | input | 1 | Active level of `dack` |
| cfg_end_pol | input | 1 | Active level of end-of-transfer |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge |
| dstb_n | input | 1 | Active-low data strobe |
| sd_i | input | 8 | Split-bus data in |
| sd_o | output | 8 | Split-bus data out |
| sd_oe | output | 1 | Split-bus output enable |
| dend_i | input | 1 | End-of-transfer pin input |
| dend_o | output | 1 | End-of-transfer pin output value |
| dend_oe | output | 1 | End-of-transfer pin output enable |
| core_wr_en | input | 1 | Core push (OUT direction) |
| core_wr_data | input | 8 | Core push data |
| core_full | output | 1 | FIFO full |
| core_rd_en | input | 1 | Core pop (IN direction) |
| core_rd_data | output | 8 | Oldest FIFO byte |
| core_rd_valid | output | 1 | FIFO not empty |
| done_flag | output | 1 | Sticky IN completion flag |
| core_done_clr | input | 1 | Clears `done_flag` |

## Verification
The assertions assume that every DMA-side input is synchronous to `clk`, that the configuration does not change while acknowledge is active, and that the core pushes only in OUT direction and pops only in IN direction. The bench sets the configuration only during reset and changes acknowledge, strobe and data at falling clock edges. It issues core pushes and pops only in the matching direction, so all stimulus stays inside those assumptions.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_LOW   = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/dsp_fifo.sv
module dsp_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             one_left
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty    = (count == '0);
    assign full     = (count == CMAX);
    assign one_left = (count == CW'(1));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dsp_strobe_fsm.sv
module dsp_strobe_fsm
    import dsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_act,
    input  logic stb_n,
    output logic xfer
);
    xfer_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (ack_act) state_nx = S_ARMED;
            S_ARMED: begin
                if (!ack_act)   state_nx = S_IDLE;
                else if (!stb_n) state_nx = S_LOW;
            end
            S_LOW: begin
                if (!ack_act)   state_nx = S_IDLE;
                else if (stb_n) state_nx = S_ARMED;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        xfer = 1'b0;
        unique case (state)
            S_LOW:   xfer = ack_act && stb_n;
            default: xfer = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsp_pin_pol.sv
module dsp_pin_pol (
    input  logic cfg_req_pol,
    input  logic cfg_ack_pol,
    input  logic cfg_end_pol,
    input  logic req_want,
    input  logic end_want,
    input  logic dack,
    input  logic dend_i,
    output logic dreq,
    output logic ack_act,
    output logic end_in_act,
    output logic dend_o
);
    assign dreq       = cfg_req_pol ? req_want : !req_want;
    assign ack_act    = (dack == cfg_ack_pol);
    assign end_in_act = (dend_i == cfg_end_pol);
    assign dend_o     = cfg_end_pol ? end_want : !end_want;
endmodule

// File: rtl/dma_split_port.sv
module dma_split_port #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dir_in,
    input  logic          cfg_req_pol,
    input  logic          cfg_ack_pol,
    input  logic          cfg_end_pol,
    output logic          dreq,
    input  logic          dack,
    input  logic          dstb_n,
    input  logic [DW-1:0] sd_i,
    output logic [DW-1:0] sd_o,
    output logic          sd_oe,
    input  logic          dend_i,
    output logic          dend_o,
    output logic          dend_oe,
    input  logic          core_wr_en,
    input  logic [DW-1:0] core_wr_data,
    output logic          core_full,
    input  logic          core_rd_en,
    output logic [DW-1:0] core_rd_data,
    output logic          core_rd_valid,
    output logic          done_flag,
    input  logic          core_done_clr
);
    logic          ack_act, end_in_act, xfer;
    logic          f_push, f_pop, f_empty, f_full, f_one;
    logic [DW-1:0] f_wdata, f_head;
    logic          req_want, end_want;

    dsp_strobe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_act (ack_act),
        .stb_n   (dstb_n),
        .xfer    (xfer)
    );

    assign f_push  = cfg_dir_in ? xfer : core_wr_en;
    assign f_wdata = cfg_dir_in ? sd_i : core_wr_data;
    assign f_pop   = cfg_dir_in ? core_rd_en : xfer;

    dsp_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push),
        .push_data (f_wdata),
        .pop       (f_pop),
        .head      (f_head),
        .empty     (f_empty),
        .full      (f_full),
        .one_left  (f_one)
    );

    assign req_want = cfg_dir_in ? !f_full : !f_empty;
    assign end_want = !cfg_dir_in && ack_act && f_one;

    dsp_pin_pol u_pol (
        .cfg_req_pol (cfg_req_pol),
        .cfg_ack_pol (cfg_ack_pol),
        .cfg_end_pol (cfg_end_pol),
        .req_want    (req_want),
        .end_want    (end_want),
        .dack        (dack),
        .dend_i      (dend_i),
        .dreq        (dreq),
        .ack_act     (ack_act),
        .end_in_act  (end_in_act),
        .dend_o      (dend_o)
    );

    assign sd_o          = f_head;
    assign sd_oe         = !cfg_dir_in && ack_act;
    assign dend_oe       = !cfg_dir_in;
    assign core_full     = f_full;
    assign core_rd_data  = f_head;
    assign core_rd_valid = !f_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        done_flag <= 1'b0;
        else if (cfg_dir_in && end_in_act) done_flag <= 1'b1;
        else if (core_done_clr)            done_flag <= 1'b0;
    end
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_dir_in,
    input logic cfg_req_pol,
    input logic cfg_ack_pol,
    input logic cfg_end_pol,
    input logic dreq,
    input logic dack,
    input logic sd_oe,
    input logic dend_i,
    input logic dend_o,
    input logic core_rd_valid,
    input logic core_full,
    input logic done_flag,
    input logic core_done_clr
);
    logic ack_on, end_in_on;
    assign ack_on    = (dack == cfg_ack_pol);
    assign end_in_on = (dend_i == cfg_end_pol);

    // R5: bus drive only in OUT direction
    a_r5_oe_out_only: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> !cfg_dir_in);

    // R9: end marker is driven only alongside a driven byte
    a_r9_end_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && dend_o == cfg_end_pol) |-> (sd_oe && core_rd_valid));

    // R10: completion flag holds until cleared
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !core_done_clr) |=> done_flag);

    // R10: a received end marker in IN direction sets the flag
    a_r10_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && end_in_on) |=> done_flag);

    // R6: no byte enters an empty IN FIFO while acknowledge is inactive
    a_r6_no_move_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && !core_rd_valid && !ack_on) |=> !core_rd_valid);

    // R3: a full IN FIFO never shows an active request
    a_r3_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && core_full) |-> (dreq != cfg_req_pol));

    // R4: an empty OUT FIFO never shows an active request
    a_r4_no_req_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && !core_rd_valid) |-> (dreq != cfg_req_pol));
endmodule

bind dma_split_port dsp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_dir_in    (cfg_dir_in),
    .cfg_req_pol   (cfg_req_pol),
    .cfg_ack_pol   (cfg_ack_pol),
    .cfg_end_pol   (cfg_end_pol),
    .dreq          (dreq),
    .dack          (dack),
    .sd_oe         (sd_oe),
    .dend_i        (dend_i),
    .dend_o        (dend_o),
    .core_rd_valid (core_rd_valid),
    .core_full     (core_full),
    .done_flag     (done_flag),
    .core_done_clr (core_done_clr)
);

// File: tb/tb_dma_split_port.sv
module tb_dma_split_port;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dir_in = 1'b1, cfg_req_pol = 1'b1, cfg_ack_pol = 1'b1, cfg_end_pol = 1'b1;
    logic       dreq, dack = 1'b0, dstb_n = 1'b1;
    logic [7:0] sd_i = '0, sd_o;
    logic       sd_oe, dend_i = 1'b0, dend_o, dend_oe;
    logic       core_wr_en = 1'b0, core_full, core_rd_en = 1'b0, core_rd_valid;
    logic [7:0] core_wr_data = '0, core_rd_data;
    logic       done_flag, core_done_clr = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_split_port dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic dir, input logic rp, input logic ap, input logic ep);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dir_in = dir; cfg_req_pol = rp; cfg_ack_pol = ap; cfg_end_pol = ep;
        dack = !ap; dstb_n = 1'b1; dend_i = !ep;
        core_wr_en = 1'b0; core_rd_en = 1'b0; core_done_clr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] d);
        dstb_n = 1'b0; sd_i = d;
        @(negedge clk);
        dstb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic core_pop();
        core_rd_en = 1'b1;
        @(negedge clk);
        core_rd_en = 1'b0;
    endtask

    task automatic core_push(input logic [7:0] d);
        core_wr_en = 1'b1; core_wr_data = d;
        @(negedge clk);
        core_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        chk("R1 valid", core_rd_valid, 0);
        chk("R1 done", done_flag, 0);
        chk("R1 oe", sd_oe, 0);
        chk("R3 R8 req empty IN", dreq, 1);
    endtask

    task automatic t_in_order();
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        dack = 1'b1;
        @(negedge clk);
        strobe(8'h11); strobe(8'h22); strobe(8'h33);
        chk("R2 valid", core_rd_valid, 1);
        chk("R2 b0", core_rd_data, 8'h11); core_pop();
        chk("R2 b1", core_rd_data, 8'h22); core_pop();
        chk("R2 b2", core_rd_data, 8'h33); core_pop();
        chk("R2 drained", core_rd_valid, 0);
    endtask

    task automatic t_in_full();
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        dack = 1'b1;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) strobe(8'(8'h40 + i));
        chk("R3 req full", dreq, 0);
        chk("R3 full", core_full, 1);
        strobe(8'hEE);
        chk("R12 still full", core_full, 1);
        chk("R12 head kept", core_rd_data, 8'h40);
        core_pop();
        chk("R3 req after pop", dreq, 1);
        for (int i = 1; i < DEPTH; i++) begin
            chk("R12 data kept", core_rd_data, 8'h40 + i);
            core_pop();
        end
        chk("R12 extra dropped", core_rd_valid, 0);
    endtask

    task automatic t_no_ack();
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        dack = 1'b0;
        @(negedge clk);
        strobe(8'h5A); strobe(8'h5B);
        chk("R6 ignored", core_rd_valid, 0);
    endtask

    task automatic t_ack_low();
        do_reset(1'b1, 1'b1, 1'b0, 1'b1);
        dack = 1'b1;
        @(negedge clk);
        strobe(8'h77);
        chk("R7 high dack inactive", core_rd_valid, 0);
        dack = 1'b0;
        @(negedge clk);
        strobe(8'h78);
        chk("R7 low dack active", core_rd_valid, 1);
        chk("R7 data", core_rd_data, 8'h78);
    endtask

    task automatic t_abort();
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        dack = 1'b1;
        @(negedge clk);
        dstb_n = 1'b0; sd_i = 8'h99;
        @(negedge clk);
        dack = 1'b0;
        @(negedge clk);
        dstb_n = 1'b1;
        @(negedge clk);
        chk("R11 aborted", core_rd_valid, 0);
    endtask

    task automatic t_out();
        do_reset(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R4 req empty", dreq, 0);
        chk("R9 oe", dend_oe, 1);
        core_push(8'hA1); core_push(8'hA2);
        chk("R4 req data", dreq, 1);
        chk("R5 oe idle", sd_oe, 0);
        dack = 1'b1;
        @(negedge clk);
        chk("R5 oe", sd_oe, 1);
        chk("R5 b0", sd_o, 8'hA1);
        chk("R9 not last", dend_o, 0);
        strobe(8'h00);
        chk("R5 b1", sd_o, 8'hA2);
        chk("R9 last", dend_o, 1);
        strobe(8'h00);
        chk("R4 req drained", dreq, 0);
        chk("R9 end cleared", dend_o, 0);
    endtask

    task automatic t_out_pol();
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 low pol inactive", dreq, 1);
        chk("R9 low pol idle", dend_o, 1);
        core_push(8'hC3);
        chk("R8 low pol active", dreq, 0);
        dack = 1'b1;
        @(negedge clk);
        chk("R9 low pol last", dend_o, 0);
    endtask

    task automatic t_in_end();
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R10 oe", dend_oe, 0);
        chk("R10 idle", done_flag, 0);
        dend_i = 1'b0;
        @(negedge clk);
        dend_i = 1'b1;
        chk("R10 set", done_flag, 1);
        repeat (3) @(negedge clk);
        chk("R10 sticky", done_flag, 1);
        core_done_clr = 1'b1;
        @(negedge clk);
        core_done_clr = 1'b0;
        chk("R10 cleared", done_flag, 0);
        dend_i = 1'b0; core_done_clr = 1'b1;
        @(negedge clk);
        dend_i = 1'b1; core_done_clr = 1'b0;
        chk("R10 set wins", done_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_in_order();
        t_in_full();
        t_no_ack();
        t_ack_low();
        t_abort();
        t_out();
        t_out_pol();
        t_in_end();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule